// File: doc/BRIEF.md
# Multi-Register Write Command Handler

This block sits behind a word-level serial receiver and serves one command: a write to a run of contiguous configuration registers. The first 16-bit word of a frame is taken as the command. If it carries the write opcode, the block takes the data words that follow and writes each one to an external register file as soon as it arrives, starting at the requested address. When input CRC checking is enabled, it then takes one CRC word and compares it with its own running CRC.

At the end of the frame the block forms a response word. The serial shifter sends that word during the next frame. The response echoes the start address and reports how many registers were really written. Slots that are read-only, unmapped or past the top of the address space still use up a data word, but they are never written. A CRC mismatch sets a sticky status bit. It does not undo the writes already made.

Named states:
- ST_IDLE: between frames.
- ST_CMD: the first word of a frame is expected.
- ST_DATA: data words are being taken.
- ST_CRC: the CRC word is expected.
- ST_DONE: the command is complete and further words are ignored.
- ST_SKIP: the frame's command is not a write.

Named transitions:
- frame_start: any state to ST_CMD.
- Write opcode seen: ST_CMD to ST_DATA.
- Other command word: ST_CMD to ST_SKIP.
- Last data word: ST_DATA to ST_CRC when crc_en is 1, or to ST_DONE when crc_en is 0.
- CRC word taken: ST_CRC to ST_DONE.
- frame_end: any state to ST_IDLE.

Top module: `wreg_write_handler`

## Requirements
- R1: The first word of a frame is decoded as a write command when bits [15:13] are 3'b011. Bits [12:7] give the start address a, and bits [6:0] give n, which is the number of data words minus one. Any other first word produces no writes and a response of 16'h0000.
- R2: The k-th data word (k from 0) is aimed at address a+k. A writable target gives a one-cycle rf_we pulse in the cycle after the word is accepted, with rf_addr = a+k and rf_wdata = the word.
- R3: A target at or above MAP_DEPTH, or whose WR_MASK bit is 0, is not written but still uses up its data word. The default map makes 2..9 and 11..19 writable. Addresses 0 and 1 are read-only, 10 is a gap, and 20 and up are unmapped.
- R4: The address walk never goes past 0x3F. Data words that would target beyond 0x3F are counted and discarded.
- R5: With crc_en=1, the word after the last data word is compared with a CRC-16. The CRC uses polynomial 0x1021, seed 0xFFFF, MSB first, and covers the command word and all data words. A mismatch sets crc_err in the following cycle. A match leaves crc_err unchanged.
- R6: Writes are made as each word arrives, so a later CRC mismatch does not remove writes already made.
- R7: crc_err stays at 1 until reset.
- R8: After the frame_end cycle of a write frame, resp_word = {3'b010, a, m}, where m is (registers written − 1) mod 128, so zero writes gives 7'h7F. The value holds until the next frame end.
- R9: If the frame ends before all n+1 data words arrive, the response counts only the registers already written, and no CRC comparison is made.
- R10: Words that arrive after the command has completed are ignored until the frame ends.
- R11: After reset, rf_we=0, resp_word=16'h0000 and crc_err=0.
- R12: A word accepted in the same cycle as frame_end is processed before the frame closes. A word accepted in the same cycle as frame_start is taken as the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crc_en | input | 1 | Input CRC word is expected and checked |
| frame_start | input | 1 | Pulse at the start of a frame |
| frame_end | input | 1 | Pulse at the end of a frame |
| rx_valid | input | 1 | rx_word holds a received word |
| rx_word | input | 16 | Received word |
| resp_word | output | 16 | Response for the next frame |
| rf_we | output | 1 | Register file write strobe |
| rf_addr | output | 6 | Register file write address |
| rf_wdata | output | 16 | Register file write data |
| crc_err | output | 1 | Sticky input CRC error status bit |

## Verification
Two events can fall in the same cycle:
- A frame boundary strobe and a word strobe.
- The CRC word (or last data word) arriving together with frame_end, so the comparison and the response capture happen on one edge.

The bench provokes both cases directly. It sends the command together with frame_start, and it sends the final data or CRC word together with frame_end, once with a good CRC and once with a corrupted one. It judges the outcome by the response word, the write strobes collected and the error bit, all sampled on the falling edge after the frame closes.

// File: rtl/wreg_pkg.sv
package wreg_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 6;
    localparam int CNT_W  = 7;
    localparam logic [2:0] OP_WRITE = 3'b011;
    localparam logic [2:0] OP_ECHO  = 3'b010;
    localparam logic [WORD_W-1:0] CRC_POLY = 16'h1021;
    localparam logic [WORD_W-1:0] CRC_SEED = 16'hFFFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_CRC,
        ST_DONE,
        ST_SKIP
    } wr_state_t;
endpackage

// File: rtl/wreg_crc16.sv
module wreg_crc16 #(
    parameter int W = 16,
    parameter logic [W-1:0] POLY = 16'h1021
) (
    input  logic [W-1:0] crc_in,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] crc_out
);
    // One full word folded in per cycle, most significant bit first.
    always_comb begin
        logic [W-1:0] c;
        c = crc_in;
        for (int i = W - 1; i >= 0; i--) begin
            if (c[W-1] ^ data_in[i]) c = {c[W-2:0], 1'b0} ^ POLY;
            else                     c = {c[W-2:0], 1'b0};
        end
        crc_out = c;
    end
endmodule

// File: rtl/wreg_map.sv
module wreg_map #(
    parameter int ADDR_W    = 6,
    parameter int MAP_DEPTH = 20,
    parameter logic [(1<<ADDR_W)-1:0] WR_MASK = '1
) (
    input  logic [ADDR_W:0] addr,       // extra MSB marks a walk past the top
    output logic            writable
);
    localparam int NADDR = 1 << ADDR_W;

    logic [NADDR-1:0] slot_ok;

    for (genvar i = 0; i < NADDR; i++) begin : g_slot
        if (i < MAP_DEPTH) begin : g_mapped
            assign slot_ok[i] = WR_MASK[i];
        end else begin : g_unmapped
            assign slot_ok[i] = 1'b0;
        end
    end

    assign writable = !addr[ADDR_W] && slot_ok[addr[ADDR_W-1:0]];
endmodule

// File: rtl/wreg_write_handler.sv
module wreg_write_handler
    import wreg_pkg::*;
#(
    parameter int MAP_DEPTH = 20,
    parameter logic [(1<<ADDR_W)-1:0] WR_MASK = 64'h0000_0000_000F_FBFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crc_en,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_word,
    output logic [WORD_W-1:0] resp_word,
    output logic              rf_we,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [WORD_W-1:0] rf_wdata,
    output logic              crc_err
);
    localparam int LEFT_W = CNT_W + 1;

    wr_state_t state_q, state_d, st_eff;

    logic [ADDR_W-1:0] base_q, base_d;
    logic [ADDR_W:0]   addr_q, addr_d;
    logic [LEFT_W-1:0] left_q, left_d;
    logic [LEFT_W-1:0] wcnt_q, wcnt_d, wcnt_m1;
    logic [WORD_W-1:0] crc_q, crc_d, crc_src, crc_next;
    logic              wrf_q, wrf_d;
    logic              err_q, err_d;
    logic              we_q, we_d;
    logic [ADDR_W-1:0] waddr_q, waddr_d;
    logic [WORD_W-1:0] wdata_q, wdata_d;
    logic [WORD_W-1:0] resp_q, resp_d;
    logic              map_ok;

    assign st_eff  = frame_start ? ST_CMD : state_q;
    assign crc_src = (st_eff == ST_CMD) ? CRC_SEED : crc_q;

    wreg_crc16 #(.W(WORD_W), .POLY(CRC_POLY)) u_crc (
        .crc_in  (crc_src),
        .data_in (rx_word),
        .crc_out (crc_next)
    );

    wreg_map #(.ADDR_W(ADDR_W), .MAP_DEPTH(MAP_DEPTH), .WR_MASK(WR_MASK)) u_map (
        .addr     (addr_q),
        .writable (map_ok)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and datapath
    always_comb begin
        state_d = st_eff;
        base_d  = base_q;
        addr_d  = addr_q;
        left_d  = left_q;
        wcnt_d  = wcnt_q;
        crc_d   = crc_q;
        wrf_d   = frame_start ? 1'b0 : wrf_q;
        err_d   = err_q;
        we_d    = 1'b0;
        waddr_d = waddr_q;
        wdata_d = wdata_q;
        resp_d  = resp_q;
        if (rx_valid) begin
            unique case (st_eff)
                ST_CMD: begin
                    if (rx_word[15:13] == OP_WRITE) begin
                        base_d  = rx_word[12:7];
                        addr_d  = {1'b0, rx_word[12:7]};
                        left_d  = {1'b0, rx_word[CNT_W-1:0]} + 1'b1;
                        wcnt_d  = '0;
                        crc_d   = crc_next;
                        wrf_d   = 1'b1;
                        state_d = ST_DATA;
                    end else begin
                        state_d = ST_SKIP;
                    end
                end
                ST_DATA: begin
                    crc_d = crc_next;
                    if (map_ok) begin
                        we_d    = 1'b1;
                        waddr_d = addr_q[ADDR_W-1:0];
                        wdata_d = rx_word;
                        wcnt_d  = wcnt_q + 1'b1;
                    end
                    if (!addr_q[ADDR_W]) addr_d = addr_q + 1'b1;
                    left_d = left_q - 1'b1;
                    if (left_q == 1) state_d = crc_en ? ST_CRC : ST_DONE;
                end
                ST_CRC: begin
                    if (rx_word != crc_q) err_d = 1'b1;
                    state_d = ST_DONE;
                end
                default: ;
            endcase
        end
        wcnt_m1 = wcnt_d - 1'b1;
        if (frame_end) begin
            state_d = ST_IDLE;
            resp_d  = wrf_d ? {OP_ECHO, base_d, wcnt_m1[CNT_W-1:0]} : '0;
        end
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            addr_q  <= '0;
            left_q  <= '0;
            wcnt_q  <= '0;
            crc_q   <= CRC_SEED;
            wrf_q   <= 1'b0;
            err_q   <= 1'b0;
            we_q    <= 1'b0;
            waddr_q <= '0;
            wdata_q <= '0;
            resp_q  <= '0;
        end else begin
            base_q  <= base_d;
            addr_q  <= addr_d;
            left_q  <= left_d;
            wcnt_q  <= wcnt_d;
            crc_q   <= crc_d;
            wrf_q   <= wrf_d;
            err_q   <= err_d;
            we_q    <= we_d;
            waddr_q <= waddr_d;
            wdata_q <= wdata_d;
            resp_q  <= resp_d;
        end
    end

    assign resp_word = resp_q;
    assign rf_we     = we_q;
    assign rf_addr   = waddr_q;
    assign rf_wdata  = wdata_q;
    assign crc_err   = err_q;
endmodule

// File: rtl/wreg_write_handler_chk.sv
module wreg_write_handler_chk #(
    parameter int MAP_DEPTH = 20,
    parameter logic [63:0] WR_MASK = 64'h0000_0000_000F_FBFC
) (
    input logic        clk,
    input logic        rst_n,
    input logic        crc_en,
    input logic        frame_end,
    input logic        rx_valid,
    input logic [15:0] resp_word,
    input logic        rf_we,
    input logic [5:0]  rf_addr,
    input logic        crc_err
);
    // R3
    wr_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> ((int'(rf_addr) < MAP_DEPTH) && WR_MASK[rf_addr]));

    // R2
    we_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> $past(rx_valid));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |=> crc_err);

    // R5
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err) |-> $past(rx_valid && crc_en));

    // R8
    resp_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(resp_word) |-> $past(frame_end));

    // R8
    resp_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_word != 16'h0000) |-> (resp_word[15:13] == 3'b010));
endmodule

bind wreg_write_handler wreg_write_handler_chk #(
    .MAP_DEPTH (MAP_DEPTH),
    .WR_MASK   (WR_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .crc_en    (crc_en),
    .frame_end (frame_end),
    .rx_valid  (rx_valid),
    .resp_word (resp_word),
    .rf_we     (rf_we),
    .rf_addr   (rf_addr),
    .crc_err   (crc_err)
);

// File: tb/wreg_write_handler_tb.sv
`timescale 1ns/1ps
module wreg_write_handler_tb;
    localparam real CLK_PERIOD = 8.0;   // 125 MHz
    localparam int  NVEC = 6;

    // {crc_en, cmd, words sent, crc good, expected resp, expected crc_err}
    localparam logic [42:0] VECS [0:NVEC-1] = '{
        {1'b0, 16'h6103, 8'd4, 1'b1, 16'h4103, 1'b0},  // R1 a=2 n=3, all writable
        {1'b1, 16'h6404, 8'd5, 1'b1, 16'h4403, 1'b0},  // R3 gap at 10, good CRC
        {1'b1, 16'h6002, 8'd3, 1'b0, 16'h4000, 1'b1},  // R5 R6 read-only 0,1; bad CRC
        {1'b0, 16'h7F04, 8'd5, 1'b1, 16'h5F7F, 1'b1},  // R4 walk past 0x3F, none written
        {1'b1, 16'h6905, 8'd3, 1'b1, 16'h4901, 1'b1},  // R9 early end after 3 of 6
        {1'b0, 16'h0000, 8'd0, 1'b1, 16'h0000, 1'b1}   // R1 not a write command
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        crc_en = 1'b0;
    logic        frame_start = 1'b0;
    logic        frame_end = 1'b0;
    logic        rx_valid = 1'b0;
    logic [15:0] rx_word = '0;
    logic [15:0] resp_word;
    logic        rf_we;
    logic [5:0]  rf_addr;
    logic [15:0] rf_wdata;
    logic        crc_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int          cap_n = 0;
    logic [5:0]  cap_a [0:79];
    logic [15:0] cap_d [0:79];
    int          exp_n;
    logic [5:0]  exp_a [0:79];
    logic [15:0] exp_d [0:79];

    wreg_write_handler u_dut (
        .clk(clk), .rst_n(rst_n), .crc_en(crc_en),
        .frame_start(frame_start), .frame_end(frame_end),
        .rx_valid(rx_valid), .rx_word(rx_word),
        .resp_word(resp_word), .rf_we(rf_we), .rf_addr(rf_addr),
        .rf_wdata(rf_wdata), .crc_err(crc_err)
    );

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    always @(negedge clk) begin
        if (rf_we && cap_n < 80) begin
            cap_a[cap_n] = rf_addr;
            cap_d[cap_n] = rf_wdata;
            cap_n++;
        end
    end

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [15:0] w);
        logic [15:0] r;
        r = c;
        for (int i = 15; i >= 0; i--) begin
            if (r[15] ^ w[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

    function automatic bit can_write(input int a);
        return (a >= 2) && (a <= 19) && (a != 10);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; frame_start = 0; frame_end = 0; rx_valid = 0; crc_en = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Sends one frame and builds the expected write list from the requirements.
    task automatic send_frame(input logic ce, input logic [15:0] cmd, input int nw,
                              input bit crc_ok, input int extra,
                              input bit join_start, input bit join_end);
        logic [15:0] wl [0:79];
        logic [15:0] c;
        int cnt, i0, a, full;
        wl[0] = cmd;
        cnt = 1;
        c = crc_upd(16'hFFFF, cmd);
        a = int'(cmd[12:7]);
        full = int'(cmd[6:0]) + 1;
        exp_n = 0;
        for (int k = 0; k < nw; k++) begin
            wl[cnt] = 16'hA500 + 16'(k * 37) + {cmd[12:7], 2'b00};
            c = crc_upd(c, wl[cnt]);
            if (cmd[15:13] == 3'b011 && (a + k) <= 63 && can_write(a + k)) begin
                exp_a[exp_n] = 6'(a + k);
                exp_d[exp_n] = wl[cnt];
                exp_n++;
            end
            cnt++;
        end
        if (ce && nw == full) begin
            wl[cnt] = crc_ok ? c : (c ^ 16'h0101);
            cnt++;
        end
        for (int k = 0; k < extra; k++) begin
            wl[cnt] = 16'h0F0F + 16'(k);
            cnt++;
        end
        crc_en = ce;
        cap_n = 0;
        @(negedge clk);
        frame_start = 1'b1;
        i0 = 0;
        if (join_start) begin
            rx_valid = 1'b1; rx_word = wl[0]; i0 = 1;
            frame_end = join_end && (cnt == 1);
        end
        for (int i = i0; i < cnt; i++) begin
            @(negedge clk);
            frame_start = 1'b0; rx_valid = 1'b1; rx_word = wl[i];
            frame_end = join_end && (i == cnt - 1);
        end
        @(negedge clk);
        frame_start = 1'b0; rx_valid = 1'b0; frame_end = !join_end;
        @(negedge clk);
        frame_end = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic check_writes(input string tag);
        bit same;
        check(cap_n == exp_n, {tag, " write count"}, 32'(cap_n), 32'(exp_n));
        same = (cap_n == exp_n);
        for (int k = 0; k < exp_n && k < cap_n; k++)
            if (cap_a[k] != exp_a[k] || cap_d[k] != exp_d[k]) same = 1'b0;
        check(same, {tag, " write addr/data"},
              (cap_n > 0) ? {10'd0, cap_a[0], cap_d[0]} : 32'hFFFF_FFFF,
              (exp_n > 0) ? {10'd0, exp_a[0], exp_d[0]} : 32'hFFFF_FFFF);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [42:0] v;
        do_reset();
        // R11 reset state
        check(rf_we == 1'b0, "R11 rf_we after reset", 32'(rf_we), 0);
        check(resp_word == 16'h0, "R11 resp after reset", 32'(resp_word), 0);
        check(crc_err == 1'b0, "R11 crc_err after reset", 32'(crc_err), 0);

        for (int n = 0; n < NVEC; n++) begin
            v = VECS[n];
            send_frame(v[42], v[41:26], int'(v[25:18]), v[17], 0, 1'b0, 1'b0);
            check(resp_word == v[16:1], $sformatf("R8 R1 R4 R9 resp vec%0d", n),
                  32'(resp_word), 32'(v[16:1]));
            check(crc_err == v[0], $sformatf("R5 R7 crc_err vec%0d", n),
                  32'(crc_err), 32'(v[0]));
            check_writes($sformatf("R2 R3 R6 vec%0d", n));
        end

        // R12 CRC word together with frame_end, good CRC
        do_reset();
        send_frame(1'b1, 16'h6201, 2, 1'b1, 0, 1'b0, 1'b1);
        check(resp_word == 16'h4201, "R12 resp joined end", 32'(resp_word), 32'h4201);
        check(crc_err == 1'b0, "R12 good CRC joined end", 32'(crc_err), 0);
        check_writes("R12 joined end");
        // R12 CRC word together with frame_end, bad CRC
        send_frame(1'b1, 16'h6201, 2, 1'b0, 0, 1'b0, 1'b1);
        check(crc_err == 1'b1, "R12 R5 bad CRC joined end", 32'(crc_err), 1);
        // R7 a later good frame leaves the error set
        send_frame(1'b1, 16'h6201, 2, 1'b1, 0, 1'b0, 1'b0);
        check(crc_err == 1'b1, "R7 sticky after good frame", 32'(crc_err), 1);
        // R12 command together with frame_start
        send_frame(1'b0, 16'h6100, 1, 1'b1, 0, 1'b1, 1'b0);
        check(resp_word == 16'h4100, "R12 resp joined start", 32'(resp_word), 32'h4100);
        check_writes("R12 joined start");
        // R10 trailing words after completion are ignored
        send_frame(1'b0, 16'h6101, 2, 1'b1, 3, 1'b0, 1'b0);
        check(resp_word == 16'h4101, "R10 resp with trailing words", 32'(resp_word), 32'h4101);
        check_writes("R10 trailing words");
        // R10 trailing words after a CRC word do not count as CRC
        do_reset();
        send_frame(1'b1, 16'h6101, 2, 1'b1, 2, 1'b0, 1'b0);
        check(crc_err == 1'b0, "R10 trailing after CRC", 32'(crc_err), 0);
        check_writes("R10 trailing after CRC");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule